// File: doc/BRIEF.md
# Posted Write Queue Controller

This block sits between a host register port and an external memory access engine. It collects write transactions in an ordered queue and hands them one at a time to the engine. Each queued entry carries an address, a data word, byte enables, a two-bit region tag and the acknowledge policy chosen for it when it was accepted. The engine itself is not part of the block. It is seen only through a request/ready handshake that launches an access and a one-cycle done pulse that reports its completion.

The region tag selects the acknowledge policy. A per-region configuration bit marks each region as posted or non-posted. A separate force bit makes the two NAND regions (command and address) posted whatever their region bit says. A posted write is acknowledged as soon as it is queued. A non-posted write is acknowledged only when the engine reports that it has finished, and the host port stays closed until then. An empty flag lets software poll until every queued write has been carried out.

Two state machines do the work. The host side has HS_OPEN and HS_HOLD. It moves from HS_OPEN to HS_HOLD when a non-posted write is accepted, and back to HS_OPEN on the done pulse of that write. The drain side has DR_IDLE, DR_ISSUE and DR_WAIT. It moves from DR_IDLE to DR_ISSUE when the queue holds an entry, and from DR_ISSUE to DR_WAIT when the engine raises ready. It leaves DR_WAIT on done, going to DR_ISSUE if entries remain and to DR_IDLE if the queue is empty.

Top module: `pwq_ctrl`

## Requirements
- R1: The queue holds up to DEPTH entries (default 8). While DEPTH entries are queued, `wr_ready` is low and no further write is taken.
- R2: Entries reach the engine in strict arrival order. Address, data, byte enables and tag are unchanged.
- R3: A posted write raises `wr_ack` for one cycle, in the cycle after the clock edge that accepted it.
- R4: After a non-posted write is accepted, `wr_ready` stays low until the engine's done pulse for that entry. `wr_ack` is raised in the cycle after that pulse and at no earlier point.
- R5: A write is posted when `cfg_region_posted[wr_tag]` is 1. It is also posted when `cfg_force_post` is 1 and `wr_tag` is 1 (NAND command region) or 2 (NAND address region). Tags 0 and 3 ignore the force bit.
- R6: `buf_empty` is high exactly when the queue holds no entry and no access is requested from or in flight in the engine.
- R7: `ext_req` and the entry fields hold steady until `ext_ready` is sampled high. After that, no new request is raised until `ext_done` is seen, so only one access is in flight at a time.
- R8: An `ext_done` pulse while no access is in flight is ignored. It produces no `wr_ack`, does not reopen a held host port, and does not change `ext_req` or `buf_empty`.
- R9: After reset, `wr_ready` and `buf_empty` are 1, and `ext_req` and `wr_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_force_post | input | 1 | Treat NAND command/address region writes as posted |
| cfg_region_posted | input | 2**TAG_W | Per-region posted policy bit, indexed by tag |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write can be accepted this cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| wr_be | input | DATA_W/8 | Host byte enables |
| wr_tag | input | TAG_W | Region tag (1 = NAND command, 2 = NAND address) |
| wr_ack | output | 1 | One-cycle write acknowledge |
| ext_req | output | 1 | Access request to the engine |
| ext_ready | input | 1 | Engine takes the current request |
| ext_addr | output | ADDR_W | Head entry address |
| ext_data | output | DATA_W | Head entry data |
| ext_be | output | DATA_W/8 | Head entry byte enables |
| ext_tag | output | TAG_W | Head entry region tag |
| ext_done | input | 1 | Engine finished the in-flight access |
| buf_empty | output | 1 | No entry queued and nothing in flight |

## Verification
The assertions check every cycle that the queue occupancy never exceeds its depth and that the port is closed when full. They also check that an accepted posted write is acknowledged on the next cycle, that accepting a non-posted write closes the port, that the empty flag never coexists with a request or a queued entry, and that a pending request keeps its fields until taken. Other behaviour can only be shown by the bench's scenarios. These are the policy decision across every tag, force bit and region setting, the arrival order of a full queue, the release of a held port by the matching done pulse rather than an earlier one, and the rejection of stray done pulses.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

    // Drain-side states: nothing to send, request raised, access in flight
    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_ISSUE = 2'd1,
        DR_WAIT  = 2'd2
    } drain_st_e;

    // Host-side states: port open, or held for a non-posted completion
    typedef enum logic {
        HS_OPEN = 1'b0,
        HS_HOLD = 1'b1
    } host_st_e;

endpackage

// File: rtl/pwq_policy.sv
module pwq_policy #(
    parameter int unsigned TAG_W   = 2,
    parameter int unsigned CMD_TAG = 1,
    parameter int unsigned ADR_TAG = 2,
    localparam int unsigned NREG   = 2 ** TAG_W
) (
    input  logic [TAG_W-1:0] tag,
    input  logic [NREG-1:0]  region_posted,
    input  logic             force_post,
    output logic             posted
);

    logic nand_region;

    always_comb begin
        nand_region = (tag == TAG_W'(CMD_TAG)) || (tag == TAG_W'(ADR_TAG));
        posted      = region_posted[tag] || (force_post && nand_region);
    end

endmodule

// File: rtl/pwq_fifo.sv
module pwq_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_comb begin
        dout  = mem[rd_ptr];
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end

endmodule

// File: rtl/pwq_drain.sv
module pwq_drain
    import pwq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_empty,
    input  logic head_posted,
    input  logic ext_ready,
    input  logic ext_done,
    output logic ext_req,
    output logic pop,
    output logic np_done,
    output logic idle
);

    drain_st_e state, state_nx;
    logic      infl_posted;

    // State register and in-flight policy capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= DR_IDLE;
            infl_posted <= 1'b0;
        end else begin
            state <= state_nx;
            if (pop) infl_posted <= head_posted;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            DR_IDLE:  if (!q_empty)  state_nx = DR_ISSUE;
            DR_ISSUE: if (ext_ready) state_nx = DR_WAIT;
            DR_WAIT:  if (ext_done)  state_nx = q_empty ? DR_IDLE : DR_ISSUE;
            default:                 state_nx = DR_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ext_req = (state == DR_ISSUE);
        pop     = ext_req && ext_ready;
        np_done = (state == DR_WAIT) && ext_done && !infl_posted;
        idle    = (state == DR_IDLE);
    end

endmodule

// File: rtl/pwq_ctrl.sv
module pwq_ctrl
    import pwq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TAG_W   = 2,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned CMD_TAG = 1,
    parameter int unsigned ADR_TAG = 2,
    localparam int unsigned BE_W   = DATA_W / 8,
    localparam int unsigned NREG   = 2 ** TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_force_post,
    input  logic [NREG-1:0]   cfg_region_posted,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              wr_ack,
    output logic              ext_req,
    input  logic              ext_ready,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_data,
    output logic [BE_W-1:0]   ext_be,
    output logic [TAG_W-1:0]  ext_tag,
    input  logic              ext_done,
    output logic              buf_empty
);

    localparam int unsigned ENT_W = ADDR_W + DATA_W + BE_W + TAG_W + 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic              accept, posted_sel, q_full, q_empty;
    logic              pop, np_done, drain_idle, head_posted;
    logic [CNT_W-1:0]  q_count;
    logic [ENT_W-1:0]  q_din, q_dout;
    host_st_e          host_st, host_nx;
    logic              ack_q;

    pwq_policy #(
        .TAG_W   (TAG_W),
        .CMD_TAG (CMD_TAG),
        .ADR_TAG (ADR_TAG)
    ) u_policy (
        .tag           (wr_tag),
        .region_posted (cfg_region_posted),
        .force_post    (cfg_force_post),
        .posted        (posted_sel)
    );

    assign q_din = {posted_sel, wr_tag, wr_be, wr_data, wr_addr};

    pwq_fifo #(
        .WIDTH (ENT_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (q_din),
        .pop   (pop),
        .dout  (q_dout),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    pwq_drain u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (q_empty),
        .head_posted (head_posted),
        .ext_ready   (ext_ready),
        .ext_done    (ext_done),
        .ext_req     (ext_req),
        .pop         (pop),
        .np_done     (np_done),
        .idle        (drain_idle)
    );

    // Host state register and acknowledge register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_st <= HS_OPEN;
            ack_q   <= 1'b0;
        end else begin
            host_st <= host_nx;
            ack_q   <= (accept && posted_sel) || np_done;
        end
    end

    // Host transitions
    always_comb begin
        host_nx = host_st;
        unique case (host_st)
            HS_OPEN: if (accept && !posted_sel) host_nx = HS_HOLD;
            HS_HOLD: if (np_done)               host_nx = HS_OPEN;
            default:                            host_nx = HS_OPEN;
        endcase
    end

    // Outputs
    always_comb begin
        wr_ready    = (host_st == HS_OPEN) && !q_full;
        accept      = wr_valid && wr_ready;
        wr_ack      = ack_q;
        ext_addr    = q_dout[0 +: ADDR_W];
        ext_data    = q_dout[ADDR_W +: DATA_W];
        ext_be      = q_dout[ADDR_W + DATA_W +: BE_W];
        ext_tag     = q_dout[ADDR_W + DATA_W + BE_W +: TAG_W];
        head_posted = q_dout[ENT_W-1];
        buf_empty   = q_empty && drain_idle;
    end

endmodule

// File: rtl/pwq_ctrl_chk.sv
module pwq_ctrl_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              wr_ack,
    input logic              posted_sel,
    input logic [CNT_W-1:0]  q_count,
    input logic              ext_req,
    input logic              ext_ready,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [DATA_W-1:0] ext_data,
    input logic              buf_empty
);

    // R1
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    // R1
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH)) |-> !wr_ready);

    // R3
    posted_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && posted_sel) |=> wr_ack);

    // R4
    np_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !posted_sel) |=> (!wr_ready && !wr_ack));

    // R6
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> (!ext_req && q_count == '0));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ready) |=> (ext_req && $stable(ext_addr) && $stable(ext_data)));

endmodule

bind pwq_ctrl pwq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_ack     (wr_ack),
    .posted_sel (posted_sel),
    .q_count    (q_count),
    .ext_req    (ext_req),
    .ext_ready  (ext_ready),
    .ext_addr   (ext_addr),
    .ext_data   (ext_data),
    .buf_empty  (buf_empty)
);

// File: tb/pwq_ctrl_tb.sv
module pwq_ctrl_tb;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int TAG_W  = 2;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_force_post = 1'b0;
    logic [3:0]        cfg_region_posted = 4'hF;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [BE_W-1:0]   wr_be = '0;
    logic [TAG_W-1:0]  wr_tag = '0;
    logic              wr_ack;
    logic              ext_req;
    logic              ext_ready = 1'b0;
    logic [ADDR_W-1:0] ext_addr;
    logic [DATA_W-1:0] ext_data;
    logic [BE_W-1:0]   ext_be;
    logic [TAG_W-1:0]  ext_tag;
    logic              ext_done = 1'b0;
    logic              buf_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    pwq_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .DEPTH  (DEPTH)
    ) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_force_post    (cfg_force_post),
        .cfg_region_posted (cfg_region_posted),
        .wr_valid          (wr_valid),
        .wr_ready          (wr_ready),
        .wr_addr           (wr_addr),
        .wr_data           (wr_data),
        .wr_be             (wr_be),
        .wr_tag            (wr_tag),
        .wr_ack            (wr_ack),
        .ext_req           (ext_req),
        .ext_ready         (ext_ready),
        .ext_addr          (ext_addr),
        .ext_data          (ext_data),
        .ext_be            (ext_be),
        .ext_tag           (ext_tag),
        .ext_done          (ext_done),
        .buf_empty         (buf_empty)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Starts and ends just after a falling edge; checks the acknowledge
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic [BE_W-1:0] b, input logic [TAG_W-1:0] t,
                            input bit exp_posted, input string req);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = b; wr_tag = t;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        check(req, "ack after accept", 64'(wr_ack), 64'(exp_posted));
    endtask

    // Engine model: take the request, then report completion
    task automatic serve_one(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input logic [BE_W-1:0] b, input logic [TAG_W-1:0] t,
                             input string req);
        while (!ext_req) @(negedge clk);
        check(req, "ext_addr", 64'(ext_addr), 64'(a));
        check(req, "ext_data", 64'(ext_data), 64'(d));
        check(req, "ext_be",   64'(ext_be),   64'(b));
        check(req, "ext_tag",  64'(ext_tag),  64'(t));
        ext_ready = 1'b1;
        @(negedge clk);
        ext_ready = 1'b0;
        check("R7", "no request while in flight", 64'(ext_req), 64'd0);
        ext_done = 1'b1;
        @(negedge clk);
        ext_done = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9", "wr_ready", 64'(wr_ready), 64'd1);
        check("R9", "buf_empty", 64'(buf_empty), 64'd1);
        check("R9", "ext_req", 64'(ext_req), 64'd0);
        check("R9", "wr_ack", 64'(wr_ack), 64'd0);

        // R1/R2/R3: fill the queue with posted writes while the engine stalls
        cfg_region_posted = 4'hF;
        for (int i = 0; i < DEPTH; i++) begin
            do_write(ADDR_W'(8'h10 + i), 32'hC0DE_0000 + 32'(i * 7), BE_W'(i + 1),
                     TAG_W'(i), 1'b1, "R3");
            if (i == 0) check("R6", "not empty after write", 64'(buf_empty), 64'd0);
        end
        for (int k = 0; k < 3; k++) begin
            check("R1", "stall when full", 64'(wr_ready), 64'd0);
            check("R7", "request held", 64'(ext_req), 64'd1);
            check("R7", "head address held", 64'(ext_addr), 64'h10);
            @(negedge clk);
        end
        for (int i = 0; i < DEPTH; i++) begin
            serve_one(ADDR_W'(8'h10 + i), 32'hC0DE_0000 + 32'(i * 7), BE_W'(i + 1),
                      TAG_W'(i), "R2");
            check("R1", "room after drain", 64'(wr_ready), 64'd1);
            check("R6", "empty only at end", 64'(buf_empty), 64'(i == DEPTH - 1));
        end

        // R8: stray done while idle
        ext_done = 1'b1;
        @(negedge clk);
        ext_done = 1'b0;
        check("R8", "no ack from stray done", 64'(wr_ack), 64'd0);
        check("R8", "empty kept", 64'(buf_empty), 64'd1);
        check("R8", "no request", 64'(ext_req), 64'd0);

        // R5/R3/R4: sweep every tag, force bit and region setting
        for (int t = 0; t < 4; t++) begin
            for (int f = 0; f < 2; f++) begin
                for (int c = 0; c < 16; c++) begin
                    bit pst;
                    logic [ADDR_W-1:0] a;
                    logic [DATA_W-1:0] d;
                    pst = c[t] || (f == 1 && (t == 1 || t == 2));
                    a = ADDR_W'((t << 5) | (f << 4) | c);
                    d = 32'hA500_0000 | 32'(a);
                    cfg_force_post = f[0];
                    cfg_region_posted = 4'(c);
                    do_write(a, d, 4'hF, TAG_W'(t), pst, "R5");
                    check("R4", "port held after non-posted", 64'(wr_ready), 64'(pst));
                    serve_one(a, d, 4'hF, TAG_W'(t), "R2");
                    check("R4", "ack after done", 64'(wr_ack), 64'(!pst));
                    check("R4", "port open after done", 64'(wr_ready), 64'd1);
                    check("R6", "empty after done", 64'(buf_empty), 64'd1);
                end
            end
        end

        // R4/R8: non-posted queued behind a posted write
        cfg_force_post = 1'b0;
        cfg_region_posted = 4'b0111;
        do_write(8'h21, 32'h1111_2222, 4'h3, 2'd0, 1'b1, "R3");
        do_write(8'h22, 32'h3333_4444, 4'hC, 2'd3, 1'b0, "R4");
        check("R4", "held behind posted", 64'(wr_ready), 64'd0);
        serve_one(8'h21, 32'h1111_2222, 4'h3, 2'd0, "R2");
        check("R4", "no ack for earlier done", 64'(wr_ack), 64'd0);
        check("R4", "still held", 64'(wr_ready), 64'd0);
        while (!ext_req) @(negedge clk);
        ext_done = 1'b1;
        @(negedge clk);
        ext_done = 1'b0;
        check("R8", "done before ready ignored", 64'(wr_ack), 64'd0);
        check("R8", "request kept", 64'(ext_req), 64'd1);
        check("R8", "port still held", 64'(wr_ready), 64'd0);
        serve_one(8'h22, 32'h3333_4444, 4'hC, 2'd3, "R2");
        check("R4", "ack on own done", 64'(wr_ack), 64'd1);
        check("R4", "port reopened", 64'(wr_ready), 64'd1);
        @(negedge clk);
        check("R4", "ack is one cycle", 64'(wr_ack), 64'd0);

        finished = 1;
        report();
        $finish;
    end

endmodule